// File: doc/BRIEF.md
# Long-Press Power Enable Controller

This block decides when a handheld device may switch its main supply on. It watches an active-low push-button and a charger-present line. It raises a single active-high enable only after the button has been held down with no break for a preset hold time. The hold time is measured in ticks from an internal prescaler, so the same logic works for any reference clock. A release before the time is up throws the partial count away. Once the enable is up, it stays up until the button is pressed again or a charger is plugged in.

A factory test mode shortens the hold time so that production testing does not wait seconds per part. To enter it, the charger line is clocked while the button is held. The eighth counted charger rising edge arms test mode and restarts the hold count with a much smaller terminal count. Edges are only counted inside an entry window that opens a setup time after the press and closes a fixed time later. Both pins are synchronised to the block clock before any edge is detected.

Top module: `pwr_hold_ctrl`

## Requirements
- R1: During and after reset, en_out is low and the inputs are taken as idle (button released = 1, charger absent = 0); with no activity en_out stays low.
- R2: With btn_n held low continuously, en_out rises at rising clock edge number 2 + HOLD_TICKS*TICK_DIV, where edge 1 is the first edge at which btn_n is low. It is still low one edge earlier.
- R3: Releasing btn_n before the hold time ends discards the count. The release leaves en_out low, and the next press needs the full R2 time again.
- R4: Once en_out is high, it stays high whether or not the button stays held, as long as no clearing event (R5, R6) occurs.
- R5: A high-to-low transition of btn_n clears en_out at the third rising edge after btn_n goes low.
- R6: A low-to-high transition of chg_in clears en_out at the third rising edge after chg_in goes high. This applies when the button is not held, and when the held button's entry window has already closed.
- R7: While the button is held, eight chg_in rising edges inside the entry window arm test mode. The hold count then restarts from zero with terminal count TEST_TICKS. en_out rises 3 + TEST_TICKS*TICK_DIV edges after the eighth rising edge is applied.
- R8: The entry window covers synchronised-hold cycle counts from SETUP_CYC up to, but not including, WIN_CYC. A charger rising edge outside it is not counted, and the partial edge count is dropped when the window closes. With fewer than eight edges inside the window, the normal hold time of R2 applies.
- R9: While test mode is armed, charger rising edges do not clear en_out. Releasing the button does not clear it either.
- R10: Releasing the button leaves test mode. The next press uses the normal hold time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Push-button, low while pressed (asynchronous) |
| chg_in | input | 1 | Charger present, high when plugged (asynchronous) |
| en_out | output | 1 | Power enable, high when the device is to be on |

## Verification
The bench times the enable to the exact edge at the end of a full hold. A design that loses or adds a synchroniser stage, or that fails to restart the prescaler on a press, would rise one or more cycles early or late. It aborts a press a few cycles short of expiry: a timer that keeps its partial count would fire early on the next press. It clocks the charger line both before the setup point and after the window closes. A design that counts those edges would arm test mode and rise far too soon. It also pulses the charger after the test-mode enable is up, which a missing guard would turn into a spurious power-off.

// File: rtl/pwrhold_pkg.sv
// Package: constants shared by the long-press power enable controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwrhold_pkg;

    // Number of counted charger rising edges that arm test mode.
    localparam int unsigned ENTRY_EDGES = 8;

    // Index of each monitored pin in the synchroniser array.
    localparam int unsigned PIN_BTN   = 0;
    localparam int unsigned PIN_CHG   = 1;
    localparam int unsigned PIN_COUNT = 2;

    // Synchronised level of a pin together with its value one cycle earlier.
    typedef struct packed {
        logic lvl;
        logic prev;
    } pin_state_t;

endpackage

// File: rtl/phc_pin_sync.sv
// Module: phc_pin_sync
// Two-flop synchroniser followed by one history flop for one asynchronous pin.
// Assumes: the pin is stable for at least one clock cycle per level, and
// IDLE is the level the pin reads while nothing drives it.
module phc_pin_sync
    import pwrhold_pkg::*;
#(
    parameter logic IDLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    output pin_state_t state_o
);

    logic [2:0] stg;

    // Shift the raw pin through two metastability stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {3{IDLE}};
        end else begin
            stg <= {stg[1:0], pin_i};
        end
    end

    assign state_o.lvl  = stg[1];
    assign state_o.prev = stg[2];

endmodule

// File: rtl/phc_tick.sv
// Module: phc_tick
// Prescaler that emits a one-cycle tick every DIV cycles while enabled.
// Assumes: run is high for the whole interval being timed; restart realigns
// the phase so the first tick arrives DIV cycles later.
module phc_tick #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count clock cycles while running; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && !restart && (cnt == LAST);

endmodule

// File: rtl/phc_entry.sv
// Module: phc_entry
// Test-mode entry detector: counts charger rising edges inside a window
// that opens SETUP_CYC cycles after the synchronised press and closes at WIN_CYC.
// Assumes: held and chg_rise come from synchronised pins; SETUP_CYC < WIN_CYC.
module phc_entry
    import pwrhold_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 33,
    parameter int unsigned WIN_CYC   = 1147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic held,
    input  logic chg_rise,
    output logic enter,
    output logic test_mode,
    output logic guard
);

    localparam int unsigned WW = $clog2(WIN_CYC + 1);
    localparam int unsigned EW = $clog2(ENTRY_EDGES);
    localparam logic [WW-1:0] SETUP_V = WW'(SETUP_CYC);
    localparam logic [WW-1:0] WIN_V   = WW'(WIN_CYC);
    localparam logic [EW-1:0] EDGE_LAST = EW'(ENTRY_EDGES - 1);

    logic [WW-1:0] wcnt;
    logic [EW-1:0] ecnt;
    logic          closed;
    logic          open_win;
    logic          count_edge;

    assign closed     = (wcnt == WIN_V);
    assign open_win   = held && (wcnt >= SETUP_V) && !closed;
    assign count_edge = open_win && chg_rise && !test_mode;
    assign enter      = count_edge && (ecnt == EDGE_LAST);
    assign guard      = held && !closed;

    // Measure how long the button has been held, saturating at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (!held) begin
            wcnt <= '0;
        end else if (!closed) begin
            wcnt <= wcnt + WW'(1);
        end
    end

    // Count charger edges inside the window; drop the count on release or close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= '0;
        end else if (!held || closed || test_mode || enter) begin
            ecnt <= '0;
        end else if (count_edge) begin
            ecnt <= ecnt + EW'(1);
        end
    end

    // Arm test mode on the final edge; leave it when the button is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_mode <= 1'b0;
        end else if (!held) begin
            test_mode <= 1'b0;
        end else if (enter) begin
            test_mode <= 1'b1;
        end
    end

endmodule

// File: rtl/phc_hold.sv
// Module: phc_hold
// Hold-time counter and enable latch. Counts prescaler ticks while the
// button is held and sets the enable at the selected terminal count.
// Assumes: clr never coincides with a set (a press starts from a zero count).
module phc_hold #(
    parameter int unsigned HOLD_TICKS = 256,
    parameter int unsigned TEST_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic held,
    input  logic tick,
    input  logic restart,
    input  logic test_mode,
    input  logic clr,
    output logic en_out
);

    localparam int unsigned MAXT = (HOLD_TICKS > TEST_TICKS) ? HOLD_TICKS : TEST_TICKS;
    localparam int unsigned HW   = $clog2(MAXT + 1);

    logic [HW-1:0] hcnt;
    logic [HW-1:0] term;
    logic          set_en;

    assign term   = test_mode ? HW'(TEST_TICKS) : HW'(HOLD_TICKS);
    assign set_en = held && !restart && tick && (hcnt == term - HW'(1));

    // Accumulate ticks during a press, saturating at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (!held || restart) begin
            hcnt <= '0;
        end else if (tick && hcnt < term) begin
            hcnt <= hcnt + HW'(1);
        end
    end

    // Latch the enable: clearing events win over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_out <= 1'b0;
        end else if (clr) begin
            en_out <= 1'b0;
        end else if (set_en) begin
            en_out <= 1'b1;
        end
    end

endmodule

// File: rtl/pwr_hold_ctrl.sv
// Module: pwr_hold_ctrl (top)
// Long-press power enable controller. It synchronises the button and
// charger pins, times a continuous press with a prescaled tick, and latches
// the enable. A factory test mode is entered by clocking the charger pin
// during a press.
// Assumes: one free-running clock; both pins are asynchronous to it.
module pwr_hold_ctrl
    import pwrhold_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 1024,
    parameter int unsigned HOLD_TICKS = 256,
    parameter int unsigned TEST_TICKS = 8,
    parameter int unsigned SETUP_CYC  = 33,
    parameter int unsigned WIN_CYC    = 1147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic chg_in,
    output logic en_out
);

    // Bit i: level read by pin i while undriven (button pulled up, charger pulled down).
    localparam logic [PIN_COUNT-1:0] IDLE_LVL = 2'b01;

    logic [PIN_COUNT-1:0] pins_raw;
    pin_state_t           pin_st [PIN_COUNT];

    logic btn_held;
    logic btn_fall;
    logic chg_rise;
    logic tick;
    logic enter;
    logic test_mode;
    logic entry_guard;
    logic clr;

    assign pins_raw[PIN_BTN] = btn_n;
    assign pins_raw[PIN_CHG] = chg_in;

    for (genvar gi = 0; gi < PIN_COUNT; gi++) begin : g_sync
        phc_pin_sync #(.IDLE(IDLE_LVL[gi])) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pins_raw[gi]),
            .state_o (pin_st[gi])
        );
    end

    assign btn_held = !pin_st[PIN_BTN].lvl;
    assign btn_fall = pin_st[PIN_BTN].prev && !pin_st[PIN_BTN].lvl;
    assign chg_rise = !pin_st[PIN_CHG].prev && pin_st[PIN_CHG].lvl;

    // A new press always clears; a plug-in clears unless entry or test mode shields it.
    assign clr = btn_fall || (chg_rise && !entry_guard && !test_mode);

    phc_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (btn_held),
        .restart (enter),
        .tick    (tick)
    );

    phc_entry #(.SETUP_CYC(SETUP_CYC), .WIN_CYC(WIN_CYC)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .held      (btn_held),
        .chg_rise  (chg_rise),
        .enter     (enter),
        .test_mode (test_mode),
        .guard     (entry_guard)
    );

    phc_hold #(.HOLD_TICKS(HOLD_TICKS), .TEST_TICKS(TEST_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .held      (btn_held),
        .tick      (tick),
        .restart   (enter),
        .test_mode (test_mode),
        .clr       (clr),
        .en_out    (en_out)
    );

endmodule

// File: rtl/phc_checker.sv
// Module: phc_checker
// Temporal properties of the long-press controller, bound to the top module.
// Assumes: signals are those of pwr_hold_ctrl; reset is synchronous active-low.
module phc_checker (
    input logic clk,
    input logic rst_n,
    input logic en_out,
    input logic btn_held,
    input logic btn_fall,
    input logic chg_rise,
    input logic entry_guard,
    input logic test_mode
);

    // The enable can only be set at the end of a press that is still held.
    p_set_while_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_out) |-> $past(btn_held));

    // A release always takes away test mode.
    p_release_leaves_test_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_held |=> !test_mode);

    // Every drop of the enable follows a press or a charger edge.
    p_drop_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_out) |-> $past(btn_fall || chg_rise));

    // A fresh press clears the enable on the next edge.
    p_press_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btn_fall |=> !en_out);

    // An unshielded charger plug-in clears the enable on the next edge.
    p_plug_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_rise && !entry_guard && !test_mode) |=> !en_out);

    // In test mode a high enable is kept.
    p_test_keeps_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && en_out) |=> en_out);

endmodule

bind pwr_hold_ctrl phc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_out      (en_out),
    .btn_held    (btn_held),
    .btn_fall    (btn_fall),
    .chg_rise    (chg_rise),
    .entry_guard (entry_guard),
    .test_mode   (test_mode)
);

// File: tb/pwr_hold_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench for pwr_hold_ctrl: stimulus tasks queue expected enable
// values for a given future cycle; a monitor compares them at falling edges.
module pwr_hold_ctrl_test;

    localparam int unsigned TICK_DIV   = 4;
    localparam int unsigned HOLD_TICKS = 20;
    localparam int unsigned TEST_TICKS = 3;
    localparam int unsigned SETUP_CYC  = 8;
    localparam int unsigned WIN_CYC    = 60;
    localparam int unsigned H_EDGES = 2 + HOLD_TICKS * TICK_DIV;
    localparam int unsigned T_EDGES = 3 + TEST_TICKS * TICK_DIV;

    typedef struct {
        int unsigned when;
        logic        val;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic chg_in = 1'b0;
    logic en_out;

    int unsigned cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t sb[$];

    pwr_hold_ctrl #(
        .TICK_DIV(TICK_DIV), .HOLD_TICKS(HOLD_TICKS), .TEST_TICKS(TEST_TICKS),
        .SETUP_CYC(SETUP_CYC), .WIN_CYC(WIN_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .chg_in(chg_in), .en_out(en_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_now(input logic exp_v, input string tag);
        n_checks++;
        if (en_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s: en_out=%b expected %b (cycle %0d)", tag, en_out, exp_v, cyc);
        end
    endtask

    task automatic expect_at(input int unsigned k, input logic v, input string tag);
        sb.push_back('{cyc + k, v, tag});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_chg(input int hi, input int lo);
        chg_in = 1'b1;
        step(hi);
        chg_in = 1'b0;
        step(lo);
    endtask

    // Monitor: compare every due expectation away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].when <= cyc) begin
                    check_now(sb[i].val, sb[i].tag);
                    sb.delete(i);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: en_out=%b expected run to finish", en_out);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        step(5);
        check_now(1'b0, "R1");
        rst_n = 1'b1;
        expect_at(1, 1'b0, "R1");
        expect_at(H_EDGES + 5, 1'b0, "R1");
        step(H_EDGES + 10);

        // R3: abort a few cycles short of expiry, then a full press.
        btn_n = 1'b0;
        step(H_EDGES - 5);
        btn_n = 1'b1;
        expect_at(20, 1'b0, "R3");
        step(30);
        btn_n = 1'b0;
        expect_at(H_EDGES - 1, 1'b0, "R3");
        expect_at(H_EDGES, 1'b1, "R2");
        expect_at(H_EDGES + 100, 1'b1, "R4");
        step(H_EDGES + 110);
        btn_n = 1'b1;
        expect_at(50, 1'b1, "R4");
        step(60);

        // R6: plug-in with button released.
        chg_in = 1'b1;
        expect_at(2, 1'b1, "R6");
        expect_at(3, 1'b0, "R6");
        step(5);
        chg_in = 1'b0;
        step(5);

        // R5: set, release, new press clears.
        btn_n = 1'b0;
        expect_at(H_EDGES, 1'b1, "R2");
        step(H_EDGES + 5);
        btn_n = 1'b1;
        step(10);
        btn_n = 1'b0;
        expect_at(2, 1'b1, "R5");
        expect_at(3, 1'b0, "R5");
        step(10);
        btn_n = 1'b1;
        step(10);

        // R7 / R9: enter test mode with eight edges inside the window.
        btn_n = 1'b0;
        step(12);
        repeat (7) pulse_chg(2, 2);
        chg_in = 1'b1;
        expect_at(T_EDGES - 1, 1'b0, "R7");
        expect_at(T_EDGES, 1'b1, "R7");
        step(2);
        chg_in = 1'b0;
        step(T_EDGES + 5);
        chg_in = 1'b1;
        expect_at(4, 1'b1, "R9");
        step(2);
        chg_in = 1'b0;
        expect_at(6, 1'b1, "R9");
        step(10);
        btn_n = 1'b1;
        expect_at(5, 1'b1, "R9");
        step(10);

        // R10: next press after leaving test mode uses the normal time.
        btn_n = 1'b0;
        expect_at(3, 1'b0, "R5");
        expect_at(H_EDGES - 1, 1'b0, "R10");
        expect_at(H_EDGES, 1'b1, "R10");
        step(H_EDGES + 5);
        btn_n = 1'b1;
        step(10);

        // R8: one edge before setup, seven inside, one after the window closes.
        btn_n = 1'b0;
        expect_at(H_EDGES - 1, 1'b0, "R8");
        expect_at(H_EDGES, 1'b1, "R8");
        step(1);
        pulse_chg(2, 9);
        repeat (7) pulse_chg(2, 2);
        step(30);
        pulse_chg(2, 2);
        step(H_EDGES);
        btn_n = 1'b1;
        step(10);

        while (sb.size() != 0) step(1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule